// File: doc/BRIEF.md
# Linked Command List Processor

This block is the control sequencer of a network controller's command unit. Software places a chain of command blocks in shared memory. Each block opens with a dword that holds a 16-bit command word in its upper half and a 16-bit status half-word in its lower half. The second dword is a link offset, and any parameters follow from byte offset 8 onward. The sequencer reads each block through a simple read port and decodes the three-bit action code. It then carries out a no-operation, a station address load or a configuration load. It writes the status back into the block's first dword and then either follows the link or stops.

Three flags in each block steer what happens after the block completes. One moves the unit to idle. Another parks it in suspended, waiting for a resume strobe. The third asks for a completion interrupt. A start strobe begins a new list while the unit is idle. Every memory address the unit issues is the base input plus an offset: the list head given at start, or a link read from a block. The station address and the first configuration bytes stay in registers inside the block. Configuration bytes beyond those are passed downstream one per cycle.

Top module: `cmd_list_engine`

## Requirements
- R1: After reset the unit is idle (`unit_state_o` = 00; 01 = active, 10 = suspended). `station_o` is all ones, `cfg_o` is zero, and no request, interrupt or forward pulse is raised.
- R2: A start strobe while idle makes the unit read the block at base + head: first the command dword, then the link dword at +4. A block that has neither end flag nor suspend flag is followed by the block at base + link.
- R3: Each finished block has its first dword rewritten as {command word unchanged, bit 15 = 1, bit 14 = 0, bit 13 = OK, bits 12:0 = 0}.
- R4: Action code 000 (command bits 18:16) does nothing but complete with OK = 1.
- R5: Action code 001 reads six bytes, in ascending byte order from offset 8 (lowest byte lane first). The first byte, which is sent first on the wire, lands in `station_o[47:40]` and the sixth in `station_o[7:0]`. The block then completes with OK = 1.
- R6: Action code 010 takes its byte count from bits 5:0 of byte 0 (offset 8) and clamps the count to the range 8 to 22. Bytes 0 to 7 are stored in `cfg_o[8*i+7:8*i]`. Bytes 8 to count-1 are emitted in order on `fwd_data_o`, one per `fwd_valid_o` pulse, with their index on `fwd_idx_o`.
- R7: A command word with any of bits 28:19 set, or with an action code above 010, completes with OK = 0 and changes neither `station_o` nor `cfg_o`.
- R8: A block with command bit 31 set sends the unit to idle and always pulses `cna_irq_o`. This flag wins when bit 30 is also set.
- R9: A block with bit 30 set (and bit 31 clear) sends the unit to suspended. In that case `cna_irq_o` pulses only when `cna_en_i` is high.
- R10: `cx_irq_o` pulses for one cycle when a block with bit 29 set completes, in the same cycle the unit leaves that block. It never pulses for a block with bit 29 clear.
- R11: A resume strobe while suspended fetches the block at base + the link of the last finished block. A resume outside the suspended state, and a start outside the idle state, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_i | input | AW | Base address added to every head and link offset |
| head_i | input | AW | List head offset taken with a start strobe |
| start_i | input | 1 | Start a new list (idle only) |
| resume_i | input | 1 | Resume from the suspended state |
| cna_en_i | input | 1 | Enables the not-active interrupt on suspend |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read byte address (dword aligned) |
| rd_ack_i | input | 1 | Read data valid this cycle |
| rd_data_i | input | 32 | Read data |
| wr_req_o | output | 1 | Status write request |
| wr_addr_o | output | AW | Status write byte address |
| wr_data_o | output | 32 | Status write dword |
| wr_ack_i | input | 1 | Write accepted this cycle |
| unit_state_o | output | 2 | 00 idle, 01 active, 10 suspended |
| cx_irq_o | output | 1 | Completion interrupt pulse |
| cna_irq_o | output | 1 | Not-active interrupt pulse |
| station_o | output | 48 | Station address, first wire byte in the top byte |
| cfg_o | output | 64 | Configuration bytes kept by the unit |
| fwd_valid_o | output | 1 | Forwarded configuration byte valid |
| fwd_idx_o | output | IDXW | Index of the forwarded byte |
| fwd_data_o | output | 8 | Forwarded configuration byte |

## Verification
The bench uses the default parameters: a 32-bit address, six station bytes, eight kept configuration bytes and a clamp range of 8 to 22. With these values, a byte count below the floor, a count above the ceiling and a count with the upper two bits set can all be reached, and all 14 forwardable bytes can be seen in one block. A base of 0x40 over a 512-byte modelled memory leaves room for chains of three blocks, suspend and resume round trips, and a nonzero list head.

// File: rtl/cle_pkg.sv
package cle_pkg;

    localparam logic [2:0] OP_NOP  = 3'd0;
    localparam logic [2:0] OP_ADDR = 3'd1;
    localparam logic [2:0] OP_CFG  = 3'd2;

    typedef enum logic [1:0] {
        UNIT_IDLE   = 2'b00,
        UNIT_ACTIVE = 2'b01,
        UNIT_SUSP   = 2'b10
    } unit_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SUSP,
        SQ_CMD,
        SQ_LINK,
        SQ_DATA,
        SQ_UNPK,
        SQ_STAT
    } seq_e;

endpackage

// File: rtl/cle_decode.sv
module cle_decode
    import cle_pkg::*;
(
    input  logic [15:0] cmd_i,
    output logic        last_o,
    output logic        susp_o,
    output logic        irq_o,
    output logic        is_addr_o,
    output logic        is_cfg_o,
    output logic        bad_o
);
    logic [2:0] op;
    logic       rsvd_set;

    always_comb begin
        op        = cmd_i[2:0];
        rsvd_set  = |cmd_i[12:3];
        last_o    = cmd_i[15];
        susp_o    = cmd_i[14];
        irq_o     = cmd_i[13];
        bad_o     = rsvd_set || (op > OP_CFG);
        is_addr_o = !bad_o && (op == OP_ADDR);
        is_cfg_o  = !bad_o && (op == OP_CFG);
    end
endmodule

// File: rtl/cle_count_clamp.sv
module cle_count_clamp #(
    parameter int unsigned CNT_MIN = 8,
    parameter int unsigned CNT_MAX = 22,
    parameter int unsigned IDXW    = 5
) (
    input  logic [5:0]      raw_i,
    output logic [IDXW-1:0] cnt_o
);
    always_comb begin
        if (32'(raw_i) < CNT_MIN)
            cnt_o = IDXW'(CNT_MIN);
        else if (32'(raw_i) > CNT_MAX)
            cnt_o = IDXW'(CNT_MAX);
        else
            cnt_o = IDXW'(raw_i);
    end
endmodule

// File: rtl/cle_byte_store.sv
module cle_byte_store #(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned KEEP       = 8,
    parameter int unsigned IDXW       = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic                    sel_addr_i,
    input  logic [IDXW-1:0]         idx_i,
    input  logic [7:0]              byte_i,
    output logic [8*ADDR_BYTES-1:0] station_o,
    output logic [8*KEEP-1:0]       keep_o,
    output logic                    fwd_valid_o,
    output logic [IDXW-1:0]         fwd_idx_o,
    output logic [7:0]              fwd_data_o
);
    logic [7:0] sta_d [ADDR_BYTES];
    logic [7:0] sta_q [ADDR_BYTES];
    logic [7:0] kp_d  [KEEP];
    logic [7:0] kp_q  [KEEP];
    logic            fv_d, fv_q;
    logic [IDXW-1:0] fi_d, fi_q;
    logic [7:0]      fb_d, fb_q;

    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_sta
        assign sta_d[k] = (wr_i && sel_addr_i && idx_i == IDXW'(k)) ? byte_i : sta_q[k];
        assign station_o[8*(ADDR_BYTES-1-k) +: 8] = sta_q[k];
    end

    for (genvar k = 0; k < KEEP; k++) begin : g_keep
        assign kp_d[k] = (wr_i && !sel_addr_i && idx_i == IDXW'(k)) ? byte_i : kp_q[k];
        assign keep_o[8*k +: 8] = kp_q[k];
    end

    always_comb begin
        fv_d = wr_i && !sel_addr_i && (32'(idx_i) >= KEEP);
        fi_d = idx_i;
        fb_d = byte_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < ADDR_BYTES; k++) sta_q[k] <= 8'hFF;
            for (int k = 0; k < KEEP; k++)       kp_q[k]  <= 8'h00;
            fv_q <= 1'b0;
            fi_q <= '0;
            fb_q <= '0;
        end else begin
            for (int k = 0; k < ADDR_BYTES; k++) sta_q[k] <= sta_d[k];
            for (int k = 0; k < KEEP; k++)       kp_q[k]  <= kp_d[k];
            fv_q <= fv_d;
            fi_q <= fi_d;
            fb_q <= fb_d;
        end
    end

    assign fwd_valid_o = fv_q;
    assign fwd_idx_o   = fi_q;
    assign fwd_data_o  = fb_q;
endmodule

// File: rtl/cmd_list_engine.sv
module cmd_list_engine
    import cle_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned CFG_KEEP   = 8,
    parameter int unsigned CFG_MIN    = 8,
    parameter int unsigned CFG_MAX    = 22,
    localparam int unsigned IDXW      = $clog2(CFG_MAX + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           base_i,
    input  logic [AW-1:0]           head_i,
    input  logic                    start_i,
    input  logic                    resume_i,
    input  logic                    cna_en_i,
    output logic                    rd_req_o,
    output logic [AW-1:0]           rd_addr_o,
    input  logic                    rd_ack_i,
    input  logic [31:0]             rd_data_i,
    output logic                    wr_req_o,
    output logic [AW-1:0]           wr_addr_o,
    output logic [31:0]             wr_data_o,
    input  logic                    wr_ack_i,
    output logic [1:0]              unit_state_o,
    output logic                    cx_irq_o,
    output logic                    cna_irq_o,
    output logic [8*ADDR_BYTES-1:0] station_o,
    output logic [8*CFG_KEEP-1:0]   cfg_o,
    output logic                    fwd_valid_o,
    output logic [IDXW-1:0]         fwd_idx_o,
    output logic [7:0]              fwd_data_o
);
    localparam logic [AW-1:0] LINK_OFS = AW'(4);
    localparam logic [AW-1:0] DATA_OFS = AW'(8);

    typedef struct packed {
        seq_e            sq;
        logic [AW-1:0]   blk;
        logic [15:0]     cmd;
        logic [AW-1:0]   link;
        logic            ok;
        logic [IDXW-1:0] idx;
        logic [IDXW-1:0] cnt;
        logic [31:0]     word;
        logic            cx;
        logic            cna;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic            dc_last, dc_susp, dc_irq, dc_addr, dc_cfg, dc_bad;
    logic [7:0]      cur_byte;
    logic [IDXW-1:0] clamp_cnt;
    logic [IDXW-1:0] eff_cnt;
    logic            byte_wr;

    cle_decode u_decode (
        .cmd_i     (ctx_q.cmd),
        .last_o    (dc_last),
        .susp_o    (dc_susp),
        .irq_o     (dc_irq),
        .is_addr_o (dc_addr),
        .is_cfg_o  (dc_cfg),
        .bad_o     (dc_bad)
    );

    assign cur_byte = ctx_q.word[{ctx_q.idx[1:0], 3'b000} +: 8];

    cle_count_clamp #(
        .CNT_MIN (CFG_MIN),
        .CNT_MAX (CFG_MAX),
        .IDXW    (IDXW)
    ) u_clamp (
        .raw_i (cur_byte[5:0]),
        .cnt_o (clamp_cnt)
    );

    cle_byte_store #(
        .ADDR_BYTES (ADDR_BYTES),
        .KEEP       (CFG_KEEP),
        .IDXW       (IDXW)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (byte_wr),
        .sel_addr_i  (dc_addr),
        .idx_i       (ctx_q.idx),
        .byte_i      (cur_byte),
        .station_o   (station_o),
        .keep_o      (cfg_o),
        .fwd_valid_o (fwd_valid_o),
        .fwd_idx_o   (fwd_idx_o),
        .fwd_data_o  (fwd_data_o)
    );

    always_comb begin
        ctx_d     = ctx_q;
        ctx_d.cx  = 1'b0;
        ctx_d.cna = 1'b0;
        byte_wr   = 1'b0;
        rd_req_o  = 1'b0;
        rd_addr_o = '0;
        wr_req_o  = 1'b0;
        wr_addr_o = '0;
        wr_data_o = '0;
        eff_cnt   = (dc_cfg && ctx_q.idx == '0) ? clamp_cnt : ctx_q.cnt;

        unique case (ctx_q.sq)
            SQ_IDLE: begin
                if (start_i) begin
                    ctx_d.blk = base_i + head_i;
                    ctx_d.sq  = SQ_CMD;
                end
            end
            SQ_SUSP: begin
                if (resume_i) begin
                    ctx_d.blk = base_i + ctx_q.link;
                    ctx_d.sq  = SQ_CMD;
                end
            end
            SQ_CMD: begin
                rd_req_o  = 1'b1;
                rd_addr_o = ctx_q.blk;
                if (rd_ack_i) begin
                    ctx_d.cmd = rd_data_i[31:16];
                    ctx_d.sq  = SQ_LINK;
                end
            end
            SQ_LINK: begin
                rd_req_o  = 1'b1;
                rd_addr_o = ctx_q.blk + LINK_OFS;
                if (rd_ack_i) begin
                    ctx_d.link = rd_data_i;
                    ctx_d.idx  = '0;
                    if (dc_bad) begin
                        ctx_d.ok = 1'b0;
                        ctx_d.sq = SQ_STAT;
                    end else if (dc_addr) begin
                        ctx_d.cnt = IDXW'(ADDR_BYTES);
                        ctx_d.sq  = SQ_DATA;
                    end else if (dc_cfg) begin
                        ctx_d.cnt = IDXW'(CFG_MAX);
                        ctx_d.sq  = SQ_DATA;
                    end else begin
                        ctx_d.ok = 1'b1;
                        ctx_d.sq = SQ_STAT;
                    end
                end
            end
            SQ_DATA: begin
                rd_req_o  = 1'b1;
                rd_addr_o = ctx_q.blk + DATA_OFS
                          + AW'({ctx_q.idx[IDXW-1:2], 2'b00});
                if (rd_ack_i) begin
                    ctx_d.word = rd_data_i;
                    ctx_d.sq   = SQ_UNPK;
                end
            end
            SQ_UNPK: begin
                byte_wr   = 1'b1;
                ctx_d.cnt = eff_cnt;
                if (ctx_q.idx + IDXW'(1) == eff_cnt) begin
                    ctx_d.ok = 1'b1;
                    ctx_d.sq = SQ_STAT;
                end else begin
                    ctx_d.idx = ctx_q.idx + IDXW'(1);
                    if (ctx_q.idx[1:0] == 2'b11)
                        ctx_d.sq = SQ_DATA;
                end
            end
            SQ_STAT: begin
                wr_req_o  = 1'b1;
                wr_addr_o = ctx_q.blk;
                wr_data_o = {ctx_q.cmd, 1'b1, 1'b0, ctx_q.ok, 13'b0};
                if (wr_ack_i) begin
                    ctx_d.cx = dc_irq;
                    if (dc_last) begin
                        ctx_d.sq  = SQ_IDLE;
                        ctx_d.cna = 1'b1;
                    end else if (dc_susp) begin
                        ctx_d.sq  = SQ_SUSP;
                        ctx_d.cna = cna_en_i;
                    end else begin
                        ctx_d.blk = base_i + ctx_q.link;
                        ctx_d.sq  = SQ_CMD;
                    end
                end
            end
            default: ctx_d.sq = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q    <= '0;
            ctx_q.sq <= SQ_IDLE;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        case (ctx_q.sq)
            SQ_IDLE: unit_state_o = UNIT_IDLE;
            SQ_SUSP: unit_state_o = UNIT_SUSP;
            default: unit_state_o = UNIT_ACTIVE;
        endcase
    end

    assign cx_irq_o  = ctx_q.cx;
    assign cna_irq_o = ctx_q.cna;
endmodule

// File: rtl/cmd_list_engine_chk.sv
module cmd_list_engine_chk #(
    parameter int unsigned IDXW    = 5,
    parameter int unsigned KEEP    = 8,
    parameter int unsigned CFG_MAX = 22
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            rd_req_o,
    input logic            wr_req_o,
    input logic            wr_ack_i,
    input logic [31:0]     wr_data_o,
    input logic [1:0]      unit_state_o,
    input logic            cx_irq_o,
    input logic            cna_irq_o,
    input logic            fwd_valid_o,
    input logic [IDXW-1:0] fwd_idx_o
);
    // R1
    state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_state_o != 2'b11);

    // R2
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));

    // R3
    status_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (wr_data_o[15] && !wr_data_o[14] && wr_data_o[12:0] == 13'b0));

    // R6
    fwd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid_o |-> (32'(fwd_idx_o) >= KEEP && 32'(fwd_idx_o) < CFG_MAX));

    // R8
    idle_entry_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(unit_state_o) == 2'b01 && unit_state_o == 2'b00) |-> cna_irq_o);

    // R9
    cna_leaves_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cna_irq_o |-> unit_state_o != 2'b01);

    // R10
    cx_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cx_irq_o |-> $past(wr_req_o && wr_ack_i));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_state_o == 2'b00 && !start_i) |=> unit_state_o == 2'b00);
endmodule

bind cmd_list_engine cmd_list_engine_chk #(
    .IDXW    (IDXW),
    .KEEP    (CFG_KEEP),
    .CFG_MAX (CFG_MAX)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .rd_req_o     (rd_req_o),
    .wr_req_o     (wr_req_o),
    .wr_ack_i     (wr_ack_i),
    .wr_data_o    (wr_data_o),
    .unit_state_o (unit_state_o),
    .cx_irq_o     (cx_irq_o),
    .cna_irq_o    (cna_irq_o),
    .fwd_valid_o  (fwd_valid_o),
    .fwd_idx_o    (fwd_idx_o)
);

// File: tb/cmd_list_engine_tb.sv
module cmd_list_engine_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [31:0] base, head;
    logic        start, resume, cna_en;
    logic        rd_req, rd_ack, wr_req, wr_ack;
    logic [31:0] rd_addr, rd_data, wr_addr, wr_data;
    logic [1:0]  ust;
    logic        cx, cna;
    logic [47:0] station;
    logic [63:0] cfg;
    logic        fwd_valid;
    logic [4:0]  fwd_idx;
    logic [7:0]  fwd_data;

    cmd_list_engine u_dut (
        .clk(clk), .rst_n(rst_n), .base_i(base), .head_i(head),
        .start_i(start), .resume_i(resume), .cna_en_i(cna_en),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
        .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_ack_i(wr_ack),
        .unit_state_o(ust), .cx_irq_o(cx), .cna_irq_o(cna),
        .station_o(station), .cfg_o(cfg),
        .fwd_valid_o(fwd_valid), .fwd_idx_o(fwd_idx), .fwd_data_o(fwd_data)
    );

    logic [31:0] mem [0:127];
    assign rd_ack  = rd_req;
    assign rd_data = mem[rd_addr[8:2]];
    assign wr_ack  = wr_req;

    int cx_n = 0, cna_n = 0, fwd_n = 0, rd_n = 0;
    logic [7:0] fwd_val [0:31];
    logic [4:0] fwd_ix  [0:31];

    always @(negedge clk) begin
        if (wr_req) mem[wr_addr[8:2]] = wr_data;
        if (cx) cx_n++;
        if (cna) cna_n++;
        if (rd_req) rd_n++;
        if (fwd_valid && fwd_n < 32) begin
            fwd_val[fwd_n] = fwd_data;
            fwd_ix[fwd_n]  = fwd_idx;
            fwd_n++;
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic wait_settle();
        for (int t = 0; t < 400; t++) begin
            if (ust != 2'b01) break;
            @(negedge clk);
        end
        #1;
    endtask

    task automatic run_from(input logic [31:0] h);
        head = h;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_settle();
    endtask

    task automatic do_resume();
        @(negedge clk) resume = 1'b1;
        @(negedge clk) resume = 1'b0;
        wait_settle();
    endtask

    typedef struct packed {
        logic [15:0] cmd;
        logic [31:0] d2;
        logic [31:0] d3;
        logic        ok;
        logic        cxe;
        logic [47:0] sta;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        {16'h8000, 32'h0,         32'h0,      1'b1, 1'b0, 48'hFFFF_FFFF_FFFF},
        {16'hA000, 32'h0,         32'h0,      1'b1, 1'b1, 48'hFFFF_FFFF_FFFF},
        {16'h8001, 32'h0100_AA00, 32'h0302,   1'b1, 1'b0, 48'h00AA_0001_0203},
        {16'hA003, 32'h5555_5555, 32'h5555,   1'b0, 1'b1, 48'h00AA_0001_0203},
        {16'h8009, 32'h1111_1111, 32'h1111,   1'b0, 1'b0, 48'h00AA_0001_0203},
        {16'hC000, 32'h0,         32'h0,      1'b1, 1'b0, 48'h00AA_0001_0203}
    };

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vec_t v;
        int c0, n0, f0, r0;
        for (int i = 0; i < 128; i++) mem[i] = 32'h0;
        rst_n = 1'b0; base = 32'h40; head = 32'h0;
        start = 1'b0; resume = 1'b0; cna_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 state", 64'(ust), 64'h0);
        chk("R1 station", 64'(station), 64'hFFFF_FFFF_FFFF);
        chk("R1 cfg", cfg, 64'h0);
        chk("R1 outputs quiet", 64'({rd_req, wr_req, cx, cna, fwd_valid}), 64'h0);

        // table walk: single blocks with end flag
        for (int i = 0; i < 6; i++) begin
            v = VECS[i];
            mem[16] = {v.cmd, 16'h0};
            mem[17] = 32'h0;
            mem[18] = v.d2;
            mem[19] = v.d3;
            c0 = cx_n; n0 = cna_n;
            run_from(32'h0);
            chk($sformatf("vec%0d R8 idle", i), 64'(ust), 64'h0);
            chk($sformatf("vec%0d R3 R4 R7 status", i), 64'(mem[16]),
                64'({v.cmd, 1'b1, 1'b0, v.ok, 13'b0}));
            chk($sformatf("vec%0d R5 R7 station", i), 64'(station), 64'(v.sta));
            chk($sformatf("vec%0d R10 cx", i), 64'(cx_n - c0), 64'(v.cxe));
            chk($sformatf("vec%0d R8 cna", i), 64'(cna_n - n0), 64'h1);
        end

        // R6 count below floor clamps to 8
        mem[16] = {16'h8002, 16'h0}; mem[17] = 32'h0;
        mem[18] = 32'h4433_2205; mem[19] = 32'h8877_6655; mem[20] = 32'hDEAD_BEEF;
        f0 = fwd_n;
        run_from(32'h0);
        chk("R6 low clamp cfg", cfg, 64'h8877_6655_4433_2205);
        chk("R6 low clamp fwd count", 64'(fwd_n - f0), 64'h0);
        chk("R3 cfg status", 64'(mem[16]), 64'h8002_A000);

        // R6 count above ceiling clamps to 22
        for (int k = 0; k < 6; k++)
            mem[18+k] = {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)};
        mem[18][7:0] = 8'h28;
        mem[16] = {16'h8002, 16'h0};
        f0 = fwd_n;
        run_from(32'h0);
        chk("R6 high clamp cfg", cfg, 64'h0706_0504_0302_0128);
        chk("R6 high clamp fwd count", 64'(fwd_n - f0), 64'd14);
        for (int q = 0; q < 14; q++) begin
            chk($sformatf("R6 fwd byte %0d", q), 64'(fwd_val[f0+q]), 64'(8 + q));
            chk($sformatf("R6 fwd index %0d", q), 64'(fwd_ix[f0+q]), 64'(8 + q));
        end

        // R6 upper two bits of byte 0 ignored: 0xCA gives 10
        mem[16] = {16'h8002, 16'h0};
        mem[18] = 32'h1312_11CA; mem[19] = 32'h1716_1514; mem[20] = 32'h1B1A_1918;
        f0 = fwd_n;
        run_from(32'h0);
        chk("R6 masked count cfg", cfg, 64'h1716_1514_1312_11CA);
        chk("R6 masked count fwd", 64'(fwd_n - f0), 64'd2);
        chk("R6 masked fwd b8", 64'(fwd_val[f0]), 64'h18);
        chk("R6 masked fwd b9", 64'(fwd_val[f0+1]), 64'h19);

        // R9 suspend with interrupt enabled, R11 start ignored, resume follows link
        cna_en = 1'b1;
        mem[16] = {16'h4000, 16'h0}; mem[17] = 32'h40;
        mem[32] = {16'h8000, 16'h0}; mem[33] = 32'h0;
        n0 = cna_n;
        run_from(32'h0);
        chk("R9 suspended", 64'(ust), 64'h2);
        chk("R9 cna enabled", 64'(cna_n - n0), 64'h1);
        chk("R3 suspend status", 64'(mem[16]), 64'h4000_A000);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 start ignored state", 64'(ust), 64'h2);
        chk("R11 start ignored mem", 64'(mem[32]), 64'h8000_0000);
        do_resume();
        chk("R11 resume idle", 64'(ust), 64'h0);
        chk("R11 resume link block", 64'(mem[32]), 64'h8000_A000);

        // R9 suspend with interrupt disabled
        cna_en = 1'b0;
        mem[16] = {16'h4000, 16'h0}; mem[32] = {16'h8000, 16'h0};
        n0 = cna_n;
        run_from(32'h0);
        chk("R9 suspended again", 64'(ust), 64'h2);
        chk("R9 cna disabled", 64'(cna_n - n0), 64'h0);
        do_resume();
        chk("R8 idle after resume", 64'(ust), 64'h0);

        // R11 resume ignored while idle
        r0 = rd_n;
        @(negedge clk) resume = 1'b1;
        @(negedge clk) resume = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 resume idle state", 64'(ust), 64'h0);
        chk("R11 resume idle reads", 64'(rd_n - r0), 64'h0);

        // R2 three-block chain from a nonzero head
        mem[20] = {16'h2000, 16'h0}; mem[21] = 32'h20;
        mem[24] = {16'h0001, 16'h0}; mem[25] = 32'h60;
        mem[26] = 32'h4433_2211;     mem[27] = 32'h0000_6655;
        mem[40] = {16'hA000, 16'h0}; mem[41] = 32'h0;
        c0 = cx_n; n0 = cna_n;
        run_from(32'h10);
        chk("R2 block1 status", 64'(mem[20]), 64'h2000_A000);
        chk("R2 block2 status", 64'(mem[24]), 64'h0001_A000);
        chk("R2 block3 status", 64'(mem[40]), 64'hA000_A000);
        chk("R5 chain station", 64'(station), 64'h1122_3344_5566);
        chk("R10 chain cx", 64'(cx_n - c0), 64'h2);
        chk("R8 chain cna", 64'(cna_n - n0), 64'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule